// File: doc/BRIEF.md
# Raster Frame Timer with Blanking Interrupt

This block produces the raster timing of a tile-based picture unit. A dot counter runs across each scanline of 341 cycles and a line counter steps through a frame of 262 lines, so one frame lasts 89,342 picture-unit cycles. The block exposes the current dot and line numbers, decodes the 256 x 240 active picture into a visible flag with zero-based pixel coordinates, and keeps a vertical-blank flag that marks the period after the active picture.

A small CPU-side register port exposes a control register and a status register. Bit 7 of the control register enables an interrupt request toward the processor. The request is the logical AND of that bit and the blank flag, so it appears once per frame when the active picture ends, and it appears on the next cycle when software enables it while the blank flag is already high. A status read returns the blank flag in bit 7 and clears it. The picture unit clock is three times the CPU clock; crossing between the two domains is left to the surrounding logic, and the port here is synchronous to the picture clock.

Top module: `raster_nmi_gen`

## Requirements
- R1: While rst_ni is low, dot_o and line_o are 0, vblank_o and nmi_o are 0, and the control register reads 0x00.
- R2: dot_o advances by one each cycle from 0 to 340 and then returns to 0; line_o advances by one at each such wrap, from 0 to 261 and then back to 0, so the frame repeats every 89,342 cycles.
- R3: visible_o is 1 exactly when dot_o is in 1..256 and line_o is in 0..239; while it is 1, pix_x_o equals dot_o minus 1 and pix_y_o equals line_o, and while it is 0 both are 0.
- R4: vblank_o becomes 1 in the cycle the counters show line 241 dot 1 and returns to 0 in the cycle they show line 261 dot 0.
- R5: nmi_o is 1 exactly when vblank_o is 1 and bit 7 of the control register is 1.
- R6: With reg_sel_i = 1 (status), reg_rdata_o shows vblank_o in bit 7 and zeros in bits 6..0 in the same cycle; a cycle with reg_rd_i = 1 and reg_sel_i = 1 clears vblank_o at its clock edge, except on the edge that sets it, where the set wins.
- R7: A cycle with reg_wr_i = 1 and reg_sel_i = 0 (control) loads reg_wdata_i into the control register at its edge; with reg_sel_i = 0, reg_rdata_o shows the control register; setting bit 7 while vblank_o is 1 makes nmi_o 1 in the next cycle.
- R8: A write with reg_sel_i = 1 leaves the control register unchanged, and a read with reg_sel_i = 0 leaves vblank_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Picture-unit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| dot_o | output | 9 | Dot number within the line, 0..340 |
| line_o | output | 9 | Line number within the frame, 0..261 |
| visible_o | output | 1 | Active picture flag |
| pix_x_o | output | 8 | Pixel column in the active picture |
| pix_y_o | output | 8 | Pixel row in the active picture |
| vblank_o | output | 1 | Vertical-blank flag |
| nmi_o | output | 1 | Interrupt request toward the CPU |

## Verification
A slip of the dot or line counter shows at dot_o and line_o on the very next cycle and shifts visible_o, the pixel coordinates and the blank window with it, so a per-cycle comparison against an independent counter model catches it at once. A blank flag that sets or clears on the wrong edge shows as a one-cycle mismatch of vblank_o and nmi_o at line 241 or 261, and a missed read-clear or a lost control write shows one cycle after the register access. The interval between two blank onsets is measured to confirm the 89,342-cycle frame.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int DOTS     = 341,
  parameter int LINES    = 262,
  parameter int SET_LINE = 241,
  parameter int CLR_LINE = 261,
  parameter int DOT_W    = $clog2(DOTS),
  parameter int LINE_W   = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DOT_W-1:0]  dot_o,
  output logic [LINE_W-1:0] line_o,
  output logic              set_evt_o,
  output logic              clr_evt_o
);
  logic last_dot, last_line;

  assign last_dot  = dot_o == DOT_W'(DOTS - 1);
  assign last_line = line_o == LINE_W'(LINES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_o  <= '0;
      line_o <= '0;
    end else if (last_dot) begin
      dot_o  <= '0;
      line_o <= last_line ? '0 : line_o + LINE_W'(1);
    end else begin
      dot_o <= dot_o + DOT_W'(1);
    end
  end

  // events fire on the edge that moves the counters onto the target dot
  assign set_evt_o = (line_o == LINE_W'(SET_LINE)) && (dot_o == '0);
  assign clr_evt_o = last_dot && (line_o == LINE_W'(CLR_LINE - 1));

  a_r2_dot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_o <= DOT_W'(DOTS - 1) && line_o <= LINE_W'(LINES - 1));
  a_r2_dot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_dot |=> dot_o == $past(dot_o) + DOT_W'(1) && $stable(line_o));
  a_r2_frame_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_dot && last_line) |=> dot_o == '0 && line_o == '0);
endmodule

// File: rtl/raster_window.sv
module raster_window #(
  parameter int VIS_W  = 256,
  parameter int VIS_H  = 240,
  parameter int DOT_W  = 9,
  parameter int LINE_W = 9,
  parameter int PX_W   = $clog2(VIS_W),
  parameter int PY_W   = $clog2(VIS_H)
) (
  input  logic [DOT_W-1:0]  dot_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              visible_o,
  output logic [PX_W-1:0]   pix_x_o,
  output logic [PY_W-1:0]   pix_y_o
);
  logic [DOT_W-1:0] dot_m1;

  assign dot_m1 = dot_i - DOT_W'(1);

  always_comb begin
    visible_o = (dot_i != '0) && (dot_i <= DOT_W'(VIS_W)) && (line_i < LINE_W'(VIS_H));
    pix_x_o   = visible_o ? PX_W'(dot_m1) : '0;
    pix_y_o   = visible_o ? PY_W'(line_i) : '0;
  end
endmodule

// File: rtl/vblank_ctrl.sv
module vblank_ctrl
  import raster_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int EN_BIT   = 7,
  parameter int FLAG_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_evt_i,
  input  logic              clr_evt_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              vblank_o,
  output logic              nmi_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] stat_w;
  logic rd_stat, wr_ctrl;

  assign rd_stat = rd_i && (sel_i == SEL_STAT);
  assign wr_ctrl = wr_i && (sel_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     vblank_o <= 1'b0;
    else if (set_evt_i)              vblank_o <= 1'b1;
    else if (clr_evt_i || rd_stat)   vblank_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata_i;
  end

  assign stat_w  = DATA_W'(vblank_o) << FLAG_BIT;
  assign rdata_o = (sel_i == SEL_STAT) ? stat_w : ctrl_q;
  assign nmi_o   = vblank_o && ctrl_q[EN_BIT];

  a_r4_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt_i |=> vblank_o);
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_evt_i |=> !vblank_o);
  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !set_evt_i) |=> !vblank_o);
  a_r7_nmi_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && wdata_i[EN_BIT] && vblank_o && !clr_evt_i && !rd_stat) |=> nmi_o);
  a_r8_stat_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_STAT) |=> $stable(ctrl_q));
endmodule

// File: rtl/raster_nmi_gen.sv
module raster_nmi_gen
  import raster_pkg::*;
#(
  parameter int DOTS_PER_LINE   = 341,
  parameter int LINES_PER_FRAME = 262,
  parameter int VIS_W           = 256,
  parameter int VIS_H           = 240,
  parameter int VBL_SET_LINE    = 241,
  parameter int VBL_CLR_LINE    = 261,
  parameter int DATA_W          = 8,
  parameter int EN_BIT          = 7,
  parameter int FLAG_BIT        = 7,
  localparam int DOT_W          = $clog2(DOTS_PER_LINE),
  localparam int LINE_W         = $clog2(LINES_PER_FRAME),
  localparam int PX_W           = $clog2(VIS_W),
  localparam int PY_W           = $clog2(VIS_H)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [DOT_W-1:0]  dot_o,
  output logic [LINE_W-1:0] line_o,
  output logic              visible_o,
  output logic [PX_W-1:0]   pix_x_o,
  output logic [PY_W-1:0]   pix_y_o,
  output logic              vblank_o,
  output logic              nmi_o
);
  logic set_evt, clr_evt;
  reg_sel_e sel;

  assign sel = reg_sel_e'(reg_sel_i);

  raster_counter #(
    .DOTS(DOTS_PER_LINE), .LINES(LINES_PER_FRAME),
    .SET_LINE(VBL_SET_LINE), .CLR_LINE(VBL_CLR_LINE),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_cnt (
    .clk_i, .rst_ni, .dot_o, .line_o,
    .set_evt_o(set_evt), .clr_evt_o(clr_evt)
  );

  raster_window #(
    .VIS_W(VIS_W), .VIS_H(VIS_H), .DOT_W(DOT_W), .LINE_W(LINE_W),
    .PX_W(PX_W), .PY_W(PY_W)
  ) u_win (
    .dot_i(dot_o), .line_i(line_o), .visible_o, .pix_x_o, .pix_y_o
  );

  vblank_ctrl #(
    .DATA_W(DATA_W), .EN_BIT(EN_BIT), .FLAG_BIT(FLAG_BIT)
  ) u_vbl (
    .clk_i, .rst_ni, .set_evt_i(set_evt), .clr_evt_i(clr_evt),
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .sel_i(sel), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .vblank_o, .nmi_o
  );

  // blanking and active picture never overlap
  a_r3_no_visible_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_o |-> !visible_o);
  a_r5_nmi_needs_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> vblank_o);
endmodule

// File: tb/raster_nmi_gen_bench.sv
module raster_nmi_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [8:0] dot, line;
  logic       visible, vblank, nmi;
  logic [7:0] px, py;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_dot = 0, m_line = 0, m_vbl = 0, m_ctrl = 0;
  longint cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_nmi_gen u_raster_nmi_gen (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(wr), .reg_rd_i(rd), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .dot_o(dot), .line_o(line),
    .visible_o(visible), .pix_x_o(px), .pix_y_o(py), .vblank_o(vblank), .nmi_o(nmi)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at dot %0d line %0d", tag, act, exp, m_dot, m_line);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_ni) begin
      m_dot = 0; m_line = 0; m_vbl = 0; m_ctrl = 0;
    end else begin
      if (m_line == 241 && m_dot == 0)      m_vbl = 1;
      else if (m_line == 260 && m_dot == 340) m_vbl = 0;
      else if (rd && sel)                   m_vbl = 0;
      if (wr && !sel) m_ctrl = wdata;
      if (m_dot == 340) begin
        m_dot = 0;
        m_line = (m_line == 261) ? 0 : m_line + 1;
      end else m_dot++;
    end
  end

  always @(negedge clk) begin
    int ev, ex, ey, er;
    ev = (m_dot >= 1 && m_dot <= 256 && m_line < 240) ? 1 : 0;
    ex = ev ? m_dot - 1 : 0;
    ey = ev ? m_line : 0;
    er = sel ? m_vbl * 128 : m_ctrl;
    chk(dot == m_dot, "R2 dot", dot, m_dot);
    chk(line == m_line, "R2 line", line, m_line);
    chk(visible == ev, "R3 visible", visible, ev);
    chk(px == ex, "R3 pix_x", px, ex);
    chk(py == ey, "R3 pix_y", py, ey);
    chk(vblank == m_vbl, "R4 vblank", vblank, m_vbl);
    chk(nmi == (m_vbl && m_ctrl[7]), "R5 nmi", nmi, m_vbl && m_ctrl[7]);
    chk(rdata == er, "R6/R7 rdata", rdata, er);
  end

  task automatic wait_pos(input int l, input int d);
    do begin @(posedge clk); #1; end while (!(m_line == l && m_dot == d));
  endtask

  task automatic reg_access(input bit w, input bit r, input bit s, input logic [7:0] data);
    wr = w; rd = r; sel = s; wdata = data;
    @(posedge clk); #1;
    wr = 0; rd = 0; sel = 0; wdata = 8'h00;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    longint t_set1, t_set2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dot == 0 && line == 0, "R1 counters in reset", {line, dot}, 0);
    chk(vblank == 0 && nmi == 0, "R1 flags in reset", {vblank, nmi}, 0);
    chk(rdata == 0, "R1 ctrl in reset", rdata, 0);
    @(posedge clk); #1; rst_ni = 1'b1;

    reg_access(1, 0, 0, 8'h80);
    sel = 0; rd = 1; @(negedge clk);
    chk(rdata == 8'h80, "R7 ctrl readback", rdata, 8'h80);
    @(posedge clk); #1; rd = 0;

    wait_pos(10, 256); @(negedge clk);
    chk(visible == 1 && px == 255 && py == 10, "R3 last visible dot", {visible, px}, {1'b1, 8'd255});
    wait_pos(10, 257); @(negedge clk);
    chk(visible == 0 && px == 0, "R3 first dot past edge", {visible, px}, 0);

    wait_pos(100, 10);
    sel = 1; @(negedge clk);
    chk(rdata == 0, "R6 status outside blank", rdata, 0);
    rd = 1; @(posedge clk); #1; rd = 0; sel = 0;

    wait_pos(241, 0); @(negedge clk);
    chk(vblank == 0, "R4 blank not yet set", vblank, 0);
    @(posedge clk); #1; t_set1 = cyc; @(negedge clk);
    chk(vblank == 1, "R4 blank set at 241/1", vblank, 1);
    chk(nmi == 1, "R5 nmi with enable", nmi, 1);

    wait_pos(250, 0);
    reg_access(0, 1, 0, 8'h00); @(negedge clk);
    chk(vblank == 1, "R8 control read keeps blank", vblank, 1);
    reg_access(1, 0, 1, 8'h00); @(negedge clk);
    sel = 0; #1;
    chk(rdata == 8'h80, "R8 status write ignored", rdata, 8'h80);
    chk(nmi == 1, "R8 nmi unchanged", nmi, 1);

    wait_pos(260, 340); @(negedge clk);
    chk(vblank == 1, "R4 blank before line 261", vblank, 1);
    @(posedge clk); #1; @(negedge clk);
    chk(vblank == 0 && nmi == 0, "R4 blank cleared at 261/0", {vblank, nmi}, 0);

    wait_pos(0, 0); @(negedge clk);
    chk(dot == 0 && line == 0, "R2 frame wrap", {line, dot}, 0);

    wait_pos(5, 0);
    reg_access(1, 0, 0, 8'h00);

    wait_pos(241, 0);
    rd = 1; sel = 1; @(negedge clk);
    chk(rdata == 0, "R6 read on set edge returns 0", rdata, 0);
    @(posedge clk); #1; rd = 0; t_set2 = cyc; @(negedge clk);
    chk(vblank == 1, "R6 set wins over read", vblank, 1);
    chk(nmi == 0, "R5 nmi gated by bit 7", nmi, 0);
    chk(t_set2 - t_set1 == 89342, "R2 frame length", t_set2 - t_set1, 89342);

    wait_pos(241, 10);
    reg_access(1, 0, 0, 8'h80); @(negedge clk);
    chk(nmi == 1, "R7 enable during blank raises nmi", nmi, 1);

    wait_pos(243, 0);
    sel = 1; @(negedge clk);
    chk(rdata == 8'h80, "R6 status shows blank", rdata, 8'h80);
    rd = 1; @(posedge clk); #1; rd = 0; @(negedge clk);
    chk(vblank == 0 && nmi == 0, "R6 read clears blank", {vblank, nmi}, 0);
    chk(rdata == 0, "R6 status after clear", rdata, 0);
    sel = 0;

    repeat (500) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule